// File: doc/BRIEF.md
# Future-Cycle Execution Slot Booker

This block sits in the allocate stage of an out-of-order core and decides, at allocation time, in which future cycle each micro-operation will issue. It keeps a circular table with one row per future clock cycle. Each row counts what has already been promised for that cycle: which functional unit of each class is taken, how many operations issue, how many register read ports are used, and how many result write buses are claimed. Because every booking is made against this table, the execution side needs no wakeup or select logic and no write-bus arbitration. It only waits the granted number of cycles.

Up to two operations arrive per cycle, in program order. Each brings its class, its source operand count, whether it writes a result, and the earliest delay at which its operands are ready. The block looks at eight consecutive rows starting at that delay. It takes the first row where the unit, an issue slot and enough read ports are free, and where a write bus is free in the row that is one latency later. It books them and returns the delay. If no row in the window fits, the operation is refused and the stage stalls. The table moves forward one row on every clock edge. The row leaving the front is wiped. A controller with two states, WARM and RUN, uses that wiping: after reset it stays in WARM for one full trip round the table, so that every row has been cleared once, and then takes the only transition, WARM to RUN. It remains in RUN until the next reset.

A granted delay d means the operation owns the row that becomes the current cycle d+1 clock edges after the grant. Loads are booked at the first-level data cache hit latency.

Top module: `slot_booker`

## Requirements
- R1: For the first 256 rising edges after reset is released the controller is in WARM. In WARM no operation is taken, and stall is 1 whenever a lane is valid. It moves to RUN on edge 256 and stays there.
- R2: In RUN a taken operation's delay is the smallest d with ready <= d <= ready+7 at which all of its resources fit. Delay d names the row that becomes current d+1 edges later.
- R3: Class codes are 0 = integer ALU (latency 1), 1 = branch (latency 1), 2 = load/store (latency 4, the first-level cache hit time) and 3 = floating point (latency 4). Each class has one unit, so two operations of the same class never share a row.
- R4: At most 2 operations are booked in any row, whatever their classes.
- R5: The source counts (opN_nsrc, 0 to 3) of the operations booked in one row add up to at most 4.
- R6: An operation with dest = 1 claims a write bus in row d + latency. A row holds at most 2 such claims. An operation with dest = 0 claims none.
- R7: When no row of the eight-row window fits, op0 is not taken, stall is 1, and nothing is booked.
- R8: A row fits only if d + latency <= 254. Any higher d counts as not fitting.
- R9: op1 is taken only in a cycle in which op0 is taken. It is searched after op0's booking, which it sees.
- R10: The table advances one row per edge. A booking made at delay d appears at delay d-1 one edge later, and a row's resources are free again once it has passed the front.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op0_valid | input | 1 | Older operation present |
| op0_class | input | 2 | Older operation class code |
| op0_nsrc | input | 2 | Older operation read-port count |
| op0_dest | input | 1 | Older operation writes a result |
| op0_ready | input | 8 | Older operation earliest delay |
| op1_valid | input | 1 | Younger operation present |
| op1_class | input | 2 | Younger operation class code |
| op1_nsrc | input | 2 | Younger operation read-port count |
| op1_dest | input | 1 | Younger operation writes a result |
| op1_ready | input | 8 | Younger operation earliest delay |
| op0_take | output | 1 | Older operation booked this cycle |
| op0_delay | output | 8 | Older operation granted delay |
| op1_take | output | 1 | Younger operation booked this cycle |
| op1_delay | output | 8 | Younger operation granted delay |
| stall | output | 1 | A valid operation was refused |

## Verification
A row holding a wrong count or a missing unit bit does not show up when it is written. It shows up only when a later request searches that row, which for a delay d means within d+1 edges, as a grant that lands one row too early or too late, or as a stall where there should be none. A pointer or wiping error first appears 256 edges later, when a stale row comes round to the window again. For that reason the bench keeps its own table indexed by absolute cycle and compares every grant, delay and stall across several full trips round the table, using crowded windows so that each limit is reached again and again.

// File: rtl/slot_booker_pkg.sv
package slot_booker_pkg;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_BR  = 2'd1,
        CLS_MEM = 2'd2,
        CLS_FPU = 2'd3
    } op_class_e;

    typedef enum logic {
        ST_WARM = 1'b0,
        ST_RUN  = 1'b1
    } bk_state_e;

    localparam int NUM_CLASSES = 4;

    function automatic int unsigned class_latency(
        input logic [1:0] cls,
        input int unsigned lat_alu,
        input int unsigned lat_br,
        input int unsigned lat_mem,
        input int unsigned lat_fpu
    );
        int unsigned lat;
        unique case (op_class_e'(cls))
            CLS_ALU: lat = lat_alu;
            CLS_BR:  lat = lat_br;
            CLS_MEM: lat = lat_mem;
            CLS_FPU: lat = lat_fpu;
            default: lat = lat_alu;
        endcase
        return lat;
    endfunction

endpackage

// File: rtl/slot_pick.sv
module slot_pick #(
    parameter int N = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hit,
    output logic          found,
    output logic [PW-1:0] idx
);
    // lowest index wins: scan from the top so later writes override
    always_comb begin
        found = |hit;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) idx = PW'(i);
        end
    end
endmodule

// File: rtl/slot_probe.sv
module slot_probe #(
    parameter int NU          = 4,
    parameter int ISSUE_MAX   = 2,
    parameter int READ_PORTS  = 4,
    parameter int WRITE_PORTS = 2,
    parameter int NSRC_W      = 2,
    parameter int CW_ISS      = 2,
    parameter int CW_RD       = 3,
    parameter int CW_WB       = 2
) (
    input  logic              in_range,
    input  logic [NU-1:0]     row_unit,
    input  logic [CW_ISS-1:0] row_iss,
    input  logic [CW_RD-1:0]  row_rd,
    input  logic [CW_WB-1:0]  row_wb,
    input  logic [1:0]        cls,
    input  logic [NSRC_W-1:0] nsrc,
    input  logic              dest,
    input  logic [NU-1:0]     x_unit,
    input  logic              x_iss,
    input  logic [NSRC_W-1:0] x_rd,
    input  logic              x_wb,
    output logic              fit
);
    logic [NU-1:0] busy;
    logic unit_ok, iss_ok, rd_ok, wb_ok;

    always_comb begin
        busy    = row_unit | x_unit;
        unit_ok = !busy[cls];
        iss_ok  = (32'(row_iss) + 32'(x_iss)) < 32'(ISSUE_MAX);
        rd_ok   = (32'(row_rd) + 32'(x_rd) + 32'(nsrc)) <= 32'(READ_PORTS);
        wb_ok   = !dest || ((32'(row_wb) + 32'(x_wb)) < 32'(WRITE_PORTS));
        fit     = in_range && unit_ok && iss_ok && rd_ok && wb_ok;
    end
endmodule

// File: rtl/slot_lane.sv
module slot_lane
    import slot_booker_pkg::*;
#(
    parameter int HORIZON     = 256,
    parameter int WINDOW      = 8,
    parameter int NU          = 4,
    parameter int ISSUE_MAX   = 2,
    parameter int READ_PORTS  = 4,
    parameter int WRITE_PORTS = 2,
    parameter int DW          = 8,
    parameter int NSRC_W      = 2,
    parameter int LAT_ALU     = 1,
    parameter int LAT_BR      = 1,
    parameter int LAT_MEM     = 4,
    parameter int LAT_FPU     = 4,
    localparam int IDXW   = $clog2(HORIZON),
    localparam int CW_ISS = $clog2(ISSUE_MAX + 1),
    localparam int CW_RD  = $clog2(READ_PORTS + 1),
    localparam int CW_WB  = $clog2(WRITE_PORTS + 1),
    localparam int PW     = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
    input  logic              enable,
    input  logic [IDXW-1:0]   base,
    input  logic [NU-1:0]     unit_q [HORIZON],
    input  logic [CW_ISS-1:0] iss_q  [HORIZON],
    input  logic [CW_RD-1:0]  rd_q   [HORIZON],
    input  logic [CW_WB-1:0]  wb_q   [HORIZON],
    input  logic              valid,
    input  logic [1:0]        cls,
    input  logic [NSRC_W-1:0] nsrc,
    input  logic              dest,
    input  logic [DW-1:0]     ready,
    input  logic              peer_take,
    input  logic [1:0]        peer_cls,
    input  logic [NSRC_W-1:0] peer_nsrc,
    input  logic              peer_dest,
    input  logic [DW-1:0]     peer_delay,
    output logic              take,
    output logic [DW-1:0]     delay,
    output logic [IDXW-1:0]   iss_idx,
    output logic [IDXW-1:0]   wb_idx
);
    int unsigned own_lat, peer_lat;
    logic [WINDOW-1:0]           fit;
    logic [WINDOW-1:0][IDXW-1:0] iss_row;
    logic [WINDOW-1:0][IDXW-1:0] wb_row;
    logic                        found;
    logic [PW-1:0]               pick;

    always_comb begin
        own_lat  = class_latency(cls, LAT_ALU, LAT_BR, LAT_MEM, LAT_FPU);
        peer_lat = class_latency(peer_cls, LAT_ALU, LAT_BR, LAT_MEM, LAT_FPU);
    end

    for (genvar k = 0; k < WINDOW; k++) begin : g_slot
        int unsigned dly, wbd;
        logic same_iss, same_wb, in_range;
        logic [NU-1:0] x_unit;
        logic [NSRC_W-1:0] x_rd;

        assign dly      = 32'(ready) + 32'(k);
        assign wbd      = dly + own_lat;
        assign in_range = wbd <= 32'(HORIZON - 2);
        // row for delay d sits one past the row that is current now
        assign iss_row[k] = IDXW'(32'(base) + 32'd1 + dly);
        assign wb_row[k]  = IDXW'(32'(base) + 32'd1 + wbd);
        // overlay of the older lane's booking made in this same cycle
        assign same_iss = peer_take && (32'(peer_delay) == dly);
        assign same_wb  = peer_take && peer_dest &&
                          ((32'(peer_delay) + peer_lat) == wbd);
        assign x_unit   = same_iss ? (NU'(1) << peer_cls) : '0;
        assign x_rd     = same_iss ? peer_nsrc : '0;

        slot_probe #(
            .NU(NU), .ISSUE_MAX(ISSUE_MAX), .READ_PORTS(READ_PORTS),
            .WRITE_PORTS(WRITE_PORTS), .NSRC_W(NSRC_W),
            .CW_ISS(CW_ISS), .CW_RD(CW_RD), .CW_WB(CW_WB)
        ) u_probe (
            .in_range (in_range),
            .row_unit (unit_q[iss_row[k]]),
            .row_iss  (iss_q[iss_row[k]]),
            .row_rd   (rd_q[iss_row[k]]),
            .row_wb   (wb_q[wb_row[k]]),
            .cls      (cls),
            .nsrc     (nsrc),
            .dest     (dest),
            .x_unit   (x_unit),
            .x_iss    (same_iss),
            .x_rd     (x_rd),
            .x_wb     (same_wb),
            .fit      (fit[k])
        );
    end

    slot_pick #(.N(WINDOW)) u_pick (
        .hit   (fit),
        .found (found),
        .idx   (pick)
    );

    always_comb begin
        take    = enable && valid && found;
        delay   = DW'(32'(ready) + 32'(pick));
        iss_idx = iss_row[pick];
        wb_idx  = wb_row[pick];
    end
endmodule

// File: rtl/slot_booker.sv
module slot_booker
    import slot_booker_pkg::*;
#(
    parameter int HORIZON     = 256,
    parameter int WINDOW      = 8,
    parameter int ISSUE_MAX   = 2,
    parameter int READ_PORTS  = 4,
    parameter int WRITE_PORTS = 2,
    parameter int DW          = 8,
    parameter int NSRC_W      = 2,
    parameter int LAT_ALU     = 1,
    parameter int LAT_BR      = 1,
    parameter int LAT_MEM     = 4,
    parameter int LAT_FPU     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op0_valid,
    input  logic [1:0]        op0_class,
    input  logic [NSRC_W-1:0] op0_nsrc,
    input  logic              op0_dest,
    input  logic [DW-1:0]     op0_ready,
    input  logic              op1_valid,
    input  logic [1:0]        op1_class,
    input  logic [NSRC_W-1:0] op1_nsrc,
    input  logic              op1_dest,
    input  logic [DW-1:0]     op1_ready,
    output logic              op0_take,
    output logic [DW-1:0]     op0_delay,
    output logic              op1_take,
    output logic [DW-1:0]     op1_delay,
    output logic              stall
);
    localparam int NU     = NUM_CLASSES;
    localparam int IDXW   = $clog2(HORIZON);
    localparam int CW_ISS = $clog2(ISSUE_MAX + 1);
    localparam int CW_RD  = $clog2(READ_PORTS + 1);
    localparam int CW_WB  = $clog2(WRITE_PORTS + 1);

    // row storage; no reset, the WARM pass wipes every row once
    logic [NU-1:0]     unit_q [HORIZON];
    logic [CW_ISS-1:0] iss_q  [HORIZON];
    logic [CW_RD-1:0]  rd_q   [HORIZON];
    logic [CW_WB-1:0]  wb_q   [HORIZON];

    bk_state_e       state_q, state_d;
    logic [IDXW-1:0] base_q;
    logic [IDXW-1:0] warm_q;
    logic            run_en;

    logic [IDXW-1:0] iss0, wb0, iss1, wb1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WARM;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARM: if (warm_q == IDXW'(HORIZON - 1)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_WARM;
        endcase
    end

    // outputs of the controller
    always_comb begin
        unique case (state_q)
            ST_WARM: run_en = 1'b0;
            ST_RUN:  run_en = 1'b1;
            default: run_en = 1'b0;
        endcase
    end

    // front pointer and warm-up count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            warm_q <= '0;
        end else begin
            base_q <= base_q + 1'b1;
            if (state_q == ST_WARM) warm_q <= warm_q + 1'b1;
        end
    end

    slot_lane #(
        .HORIZON(HORIZON), .WINDOW(WINDOW), .NU(NU), .ISSUE_MAX(ISSUE_MAX),
        .READ_PORTS(READ_PORTS), .WRITE_PORTS(WRITE_PORTS), .DW(DW),
        .NSRC_W(NSRC_W), .LAT_ALU(LAT_ALU), .LAT_BR(LAT_BR),
        .LAT_MEM(LAT_MEM), .LAT_FPU(LAT_FPU)
    ) u_lane0 (
        .enable     (run_en),
        .base       (base_q),
        .unit_q     (unit_q),
        .iss_q      (iss_q),
        .rd_q       (rd_q),
        .wb_q       (wb_q),
        .valid      (op0_valid),
        .cls        (op0_class),
        .nsrc       (op0_nsrc),
        .dest       (op0_dest),
        .ready      (op0_ready),
        .peer_take  (1'b0),
        .peer_cls   (2'd0),
        .peer_nsrc  ('0),
        .peer_dest  (1'b0),
        .peer_delay ('0),
        .take       (op0_take),
        .delay      (op0_delay),
        .iss_idx    (iss0),
        .wb_idx     (wb0)
    );

    // younger lane only runs once the older one is booked
    slot_lane #(
        .HORIZON(HORIZON), .WINDOW(WINDOW), .NU(NU), .ISSUE_MAX(ISSUE_MAX),
        .READ_PORTS(READ_PORTS), .WRITE_PORTS(WRITE_PORTS), .DW(DW),
        .NSRC_W(NSRC_W), .LAT_ALU(LAT_ALU), .LAT_BR(LAT_BR),
        .LAT_MEM(LAT_MEM), .LAT_FPU(LAT_FPU)
    ) u_lane1 (
        .enable     (run_en && op0_take),
        .base       (base_q),
        .unit_q     (unit_q),
        .iss_q      (iss_q),
        .rd_q       (rd_q),
        .wb_q       (wb_q),
        .valid      (op1_valid),
        .cls        (op1_class),
        .nsrc       (op1_nsrc),
        .dest       (op1_dest),
        .ready      (op1_ready),
        .peer_take  (op0_take),
        .peer_cls   (op0_class),
        .peer_nsrc  (op0_nsrc),
        .peer_dest  (op0_dest),
        .peer_delay (op0_delay),
        .take       (op1_take),
        .delay      (op1_delay),
        .iss_idx    (iss1),
        .wb_idx     (wb1)
    );

    always_comb begin
        stall = (op0_valid && !op0_take) || (op1_valid && !op1_take);
    end

    // row update: wipe the front row, add this cycle's bookings elsewhere
    always_ff @(posedge clk) begin
        for (int r = 0; r < HORIZON; r++) begin
            if (IDXW'(r) == base_q) begin
                unit_q[r] <= '0;
                iss_q[r]  <= '0;
                rd_q[r]   <= '0;
                wb_q[r]   <= '0;
            end else begin
                unit_q[r] <= unit_q[r]
                    | ((op0_take && iss0 == IDXW'(r)) ? (NU'(1) << op0_class) : '0)
                    | ((op1_take && iss1 == IDXW'(r)) ? (NU'(1) << op1_class) : '0);
                iss_q[r] <= iss_q[r]
                    + CW_ISS'(op0_take && iss0 == IDXW'(r))
                    + CW_ISS'(op1_take && iss1 == IDXW'(r));
                rd_q[r] <= rd_q[r]
                    + ((op0_take && iss0 == IDXW'(r)) ? CW_RD'(op0_nsrc) : '0)
                    + ((op1_take && iss1 == IDXW'(r)) ? CW_RD'(op1_nsrc) : '0);
                wb_q[r] <= wb_q[r]
                    + CW_WB'(op0_take && op0_dest && wb0 == IDXW'(r))
                    + CW_WB'(op1_take && op1_dest && wb1 == IDXW'(r));
            end
        end
    end
endmodule

// File: rtl/slot_booker_chk.sv
module slot_booker_chk
    import slot_booker_pkg::*;
#(
    parameter int HORIZON = 256,
    parameter int WINDOW  = 8,
    parameter int DW      = 8,
    parameter int LAT_ALU = 1,
    parameter int LAT_BR  = 1,
    parameter int LAT_MEM = 4,
    parameter int LAT_FPU = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op0_valid,
    input logic [1:0]    op0_class,
    input logic [DW-1:0] op0_ready,
    input logic [1:0]    op1_class,
    input logic [DW-1:0] op1_ready,
    input logic          op0_take,
    input logic [DW-1:0] op0_delay,
    input logic          op1_take,
    input logic [DW-1:0] op1_delay,
    input logic          stall
);
    localparam int CW = $clog2(HORIZON + 1);
    logic [CW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    seen <= '0;
        else if (seen < CW'(HORIZON))  seen <= seen + 1'b1;
    end

    // R1
    warm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen < CW'(HORIZON)) |-> (!op0_take && !op1_take));

    // R9
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op1_take |-> op0_take);

    // R2
    window0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op0_take |-> (op0_delay >= op0_ready &&
                      32'(op0_delay) < 32'(op0_ready) + 32'(WINDOW)));

    // R2
    window1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op1_take |-> (op1_delay >= op1_ready &&
                      32'(op1_delay) < 32'(op1_ready) + 32'(WINDOW)));

    // R8
    horizon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op0_take |-> (32'(op0_delay) +
            class_latency(op0_class, LAT_ALU, LAT_BR, LAT_MEM, LAT_FPU)
            <= 32'(HORIZON - 2)));

    // R3
    one_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op0_take && op1_take && op0_class == op1_class) |-> (op0_delay != op1_delay));

    // R7
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op0_valid && !op0_take) |-> stall);
endmodule

bind slot_booker slot_booker_chk #(
    .HORIZON(HORIZON), .WINDOW(WINDOW), .DW(DW),
    .LAT_ALU(LAT_ALU), .LAT_BR(LAT_BR), .LAT_MEM(LAT_MEM), .LAT_FPU(LAT_FPU)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op0_valid (op0_valid),
    .op0_class (op0_class),
    .op0_ready (op0_ready),
    .op1_class (op1_class),
    .op1_ready (op1_ready),
    .op0_take  (op0_take),
    .op0_delay (op0_delay),
    .op1_take  (op1_take),
    .op1_delay (op1_delay),
    .stall     (stall)
);

// File: tb/slot_booker_test.sv
module slot_booker_test;
    localparam int CLK_PERIOD = 10;
    localparam int HZ = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic       op0_valid = 0, op0_dest = 0, op1_valid = 0, op1_dest = 0;
    logic [1:0] op0_class = 0, op0_nsrc = 0, op1_class = 0, op1_nsrc = 0;
    logic [7:0] op0_ready = 0, op1_ready = 0;
    logic       op0_take, op1_take, stall;
    logic [7:0] op0_delay, op1_delay;

    int checks = 0;
    int errors = 0;
    int edges = 0;
    int now = 0;
    bit finished = 0;
    logic [31:0] lf = 32'h1badcafe;

    bit [3:0] m_unit [HZ];
    int m_iss [HZ];
    int m_rd  [HZ];
    int m_wb  [HZ];

    always #(CLK_PERIOD / 2) clk = ~clk;

    slot_booker uut (
        .clk(clk), .rst_n(rst_n),
        .op0_valid(op0_valid), .op0_class(op0_class), .op0_nsrc(op0_nsrc),
        .op0_dest(op0_dest), .op0_ready(op0_ready),
        .op1_valid(op1_valid), .op1_class(op1_class), .op1_nsrc(op1_nsrc),
        .op1_dest(op1_dest), .op1_ready(op1_ready),
        .op0_take(op0_take), .op0_delay(op0_delay),
        .op1_take(op1_take), .op1_delay(op1_delay), .stall(stall)
    );

    function automatic int lat_of(input int c);
        return (c >= 2) ? 4 : 1;   // R3 latencies
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic search(input int c, input int n, input int dst, input int rdy,
                          output bit ok, output int d);
        ok = 0;
        d = 0;
        for (int k = 0; k < 8; k++) begin
            int dd, ir, wr;
            dd = rdy + k;
            ir = (now + 1 + dd) % HZ;
            wr = (now + 1 + dd + lat_of(c)) % HZ;
            if (!ok && dd + lat_of(c) <= HZ - 2 && !m_unit[ir][c] &&
                m_iss[ir] < 2 && m_rd[ir] + n <= 4 && (dst == 0 || m_wb[wr] < 2)) begin
                ok = 1;
                d = dd;
            end
        end
    endtask

    task automatic book(input int c, input int n, input int dst, input int d);
        int ir, wr;
        ir = (now + 1 + d) % HZ;
        wr = (now + 1 + d + lat_of(c)) % HZ;
        m_unit[ir][c] = 1'b1;
        m_iss[ir] += 1;
        m_rd[ir] += n;
        if (dst != 0) m_wb[wr] += 1;
    endtask

    task automatic step(input bit av, input int ac, input int an, input int adst, input int ar,
                        input bit bv, input int bc, input int bn, input int bdst, input int br,
                        input string tag);
        bit ea, eb, warm;
        int ed, fd;
        warm = edges < HZ;
        op0_valid = av; op0_class = 2'(ac); op0_nsrc = 2'(an);
        op0_dest = adst[0]; op0_ready = 8'(ar);
        op1_valid = bv; op1_class = 2'(bc); op1_nsrc = 2'(bn);
        op1_dest = bdst[0]; op1_ready = 8'(br);
        ea = 0; eb = 0; ed = 0; fd = 0;
        if (av && !warm) begin
            search(ac, an, adst, ar, ea, ed);
            if (ea) book(ac, an, adst, ed);
        end
        if (bv && ea) begin
            search(bc, bn, bdst, br, eb, fd);
            if (eb) book(bc, bn, bdst, fd);
        end
        #1;
        check(op0_take == ea, tag, "op0_take", int'(op0_take), int'(ea));
        if (ea) check(int'(op0_delay) == ed, tag, "op0_delay", int'(op0_delay), ed);
        check(op1_take == eb, tag, "op1_take", int'(op1_take), int'(eb));
        if (eb) check(int'(op1_delay) == fd, tag, "op1_delay", int'(op1_delay), fd);
        check(stall == ((av && !ea) || (bv && !eb)), tag, "stall", int'(stall),
              int'((av && !ea) || (bv && !eb)));
        @(posedge clk);
        m_unit[now] = '0; m_iss[now] = 0; m_rd[now] = 0; m_wb[now] = 0;
        now = (now + 1) % HZ;
        edges++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < HZ; r++) begin
            m_unit[r] = '0; m_iss[r] = 0; m_rd[r] = 0; m_wb[r] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: warm-up, valid requests refused
        for (int i = 0; i < HZ; i++) step(1, 0, 1, 1, 0, 1, 1, 0, 0, 0, "R1");

        // R2: plain first fit
        step(1, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 0, 1, 1, 5, 0, 0, 0, 0, 0, "R2");
        // R3: same class on both lanes pushes the younger one back
        step(1, 0, 1, 1, 3, 1, 0, 1, 1, 3, "R3");
        step(1, 3, 2, 1, 12, 1, 3, 2, 1, 12, "R3");
        // R4: two ops fill a row, a third in the next cycle moves on
        step(1, 0, 0, 0, 10, 1, 1, 0, 0, 10, "R4");
        step(1, 2, 0, 0, 9, 0, 0, 0, 0, 0, "R4");
        // R5: read ports
        step(1, 0, 3, 0, 20, 1, 1, 2, 0, 20, "R5");
        step(1, 2, 1, 0, 19, 0, 0, 0, 0, 0, "R5");
        // R6: write buses
        step(1, 0, 0, 1, 40, 1, 1, 0, 1, 40, "R6");
        step(1, 3, 0, 1, 36, 0, 0, 0, 0, 0, "R6");
        step(1, 3, 0, 0, 36, 0, 0, 0, 0, 0, "R6");
        // R7: fill eight rows of the load/store unit, then a refusal
        for (int i = 0; i < 4; i++) step(1, 2, 0, 0, 60 - i, 1, 2, 0, 0, 60 - i, "R7");
        step(1, 2, 0, 0, 56, 1, 0, 0, 0, 0, "R7");
        step(1, 2, 0, 0, 55, 0, 0, 0, 0, 0, "R7");
        // R8: horizon edge
        step(1, 0, 0, 1, 253, 0, 0, 0, 0, 0, "R8");
        step(1, 2, 0, 1, 250, 0, 0, 0, 0, 0, "R8");
        step(1, 2, 0, 1, 251, 0, 0, 0, 0, 0, "R8");
        step(1, 3, 0, 0, 248, 1, 0, 0, 0, 249, "R8");
        // R9: younger lane refused when the older one is
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 251, 1, 1, 0, 0, 0, "R9");
        // R10: a booking slides one row per edge
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R10");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        idle(HZ);
        step(1, 2, 0, 0, 56, 0, 0, 0, 0, 0, "R10");

        // R3/R6: exhaustive class x sources x dest sweep at ready 0
        for (int c = 0; c < 4; c++)
            for (int n = 0; n < 4; n++)
                for (int d = 0; d < 2; d++)
                    step(1, c, n, d, 0, 1, c, 3 - n, 1 - d, 0, "R3");

        // R4/R5/R6/R7: dense mixed traffic over several trips round the table
        for (int i = 0; i < 3000; i++) begin
            int ar, br;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            ar = int'(lf[10:7]);
            br = int'(lf[19:16]);
            if (lf[24:22] == 3'd0) ar = 240 + int'(lf[29:26]);
            step(lf[0] | lf[1], int'(lf[3:2]), int'(lf[5:4]), int'(lf[6]), ar,
                 lf[11], int'(lf[13:12]), int'(lf[15:14]), int'(lf[20]), br, "R4");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule